// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block takes a DDR2 memory device from a freshly powered, clock-running state to a fully configured state, ready for normal traffic. It drives the clock-enable, chip-select, row/column strobe, write-enable, bank-address and address pins. It holds the device quiet for the power-settle interval and then raises clock enable. After that it issues the fixed series of precharge, mode-register and refresh commands that the device needs before it can be used. Each wait is converted from nanoseconds to controller clock cycles at elaboration, using the clock frequency parameter.

The sequence starts when the power-stable input is sampled high. From then on it runs to completion without looking at that input again. When the last mode-register load has been spaced out and the DLL has had its lock time, the sequencer raises `init_done` and keeps it high. At that point it parks the bus on NOP with clock enable high, so a downstream controller can take the bus over. All pins are plain control signals. There is no data stream and no back-pressure. A synchronous reset returns the sequencer to its idle state at any point.

Command words are written as {cs_n, ras_n, cas_n, we_n}: NOP is 0111, PRECHARGE is 0010, LOAD MODE is 0000 and AUTO REFRESH is 0001. All outputs are registered, so each pin value appears one clock edge after the internal step that produces it.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is asserted, and afterwards while `pwr_stable` has not yet been sampled high, `cke` is 0, the command is NOP (0111), `ba` and `addr` are zero and `init_done` is 0.
- R2: After the first edge that samples `pwr_stable` high, `cke` stays low for exactly PWR_C+1 sampled cycles, where PWR_C = ceil(PWR_WAIT_NS*CLK_MHZ/1000). Only NOP appears on the command pins during that time.
- R3: Once `cke` is high it stays high until reset, even if `pwr_stable` is later dropped.
- R4: With `cke` high, the commands appear in this order: PRECHARGE, LOAD MODE ba=2, LOAD MODE ba=3, LOAD MODE ba=1, LOAD MODE ba=0 (DLL reset), PRECHARGE, AUTO REFRESH, AUTO REFRESH, LOAD MODE ba=0 (final). Every cycle between two commands carries NOP.
- R5: The first PRECHARGE comes CKE_C cycles after `cke` rises. Each later command follows the previous one by MRD_C cycles after a LOAD MODE, RP_C cycles after a PRECHARGE, and RFC_C cycles after an AUTO REFRESH. Each of these counts is the ceiling of its nanosecond parameter times CLK_MHZ/1000, with a minimum of 1.
- R6: Each PRECHARGE drives `addr[10]`=1 (all banks), with every other address bit and `ba` zero. Each AUTO REFRESH drives `ba` and `addr` zero.
- R7: The LOAD MODE with ba=2 drives `addr[7]` equal to `srt_fast`. All its other address bits are zero.
- R8: The LOAD MODE with ba=3 drives an all-zero address. The LOAD MODE with ba=1 drives `addr[0]`=0 (DLL enabled) and `addr[9:7]`=EMR1_HI, with all other bits zero.
- R9: The DLL-reset LOAD MODE (ba=0) drives only `addr[8]`=1. The final LOAD MODE (ba=0) drives MR_OPER with bit 8 forced to 0.
- R10: `init_done` rises no earlier than DLL_LOCK_CYC cycles after the DLL-reset command. With the default parameters it rises exactly DLL_LOCK_CYC cycles after it. From then on it stays high, with `cke` high and NOP on the command pins, until reset.
- R11: A synchronous reset at any step clears `init_done` and drops `cke` on the next edge. A new sequence then starts only when `pwr_stable` is sampled high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_stable | input | 1 | Supplies and device clock are stable; starts the sequence |
| srt_fast | input | 1 | Self-refresh rate select written into bit 7 of the ba=2 register |
| cke | output | 1 | Device clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address / mode register select |
| addr | output | ROW_W | Address / mode register contents |
| init_done | output | 1 | Initialization finished; bus handed over |

## Verification
A corrupted step register shows up at the pins one edge later as a command that is out of order or carries the wrong register contents. A corrupted step counter moves a command by one or more cycles, which the gap measured between consecutive commands exposes at that same command. A fault in the DLL-lock counter stays hidden through all the command traffic. It becomes visible only as a misplaced rise of `init_done`, some two hundred cycles after the DLL-reset command. The clock-enable and done flags are watched on every sampled cycle, so a single-cycle glitch on either is caught in the cycle it occurs.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PWR,
    ST_CKEW,
    ST_PRE1,
    ST_EMR2,
    ST_EMR3,
    ST_EMR1,
    ST_MRRST,
    ST_PRE2,
    ST_REF1,
    ST_REF2,
    ST_MRFIN,
    ST_DONE
  } step_e;

  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_MRS = 4'b0000;
  localparam logic [3:0] CMD_REF = 4'b0001;

  // Round a nanosecond interval up to whole clock cycles, never below one.
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/init_dn_counter.sv
module init_dn_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // Timed waits start from exactly the loaded count.
  assert_load_takes_R5: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val)));

  // An expired wait stays expired until reloaded.
  assert_zero_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (zero && !load) |=> zero);

endmodule

// File: rtl/init_cmd_decode.sv
module init_cmd_decode
  import ddr2_init_pkg::*;
#(
  parameter int               ROW_W   = 14,
  parameter int               BA_W    = 3,
  parameter logic [2:0]       EMR1_HI = 3'b000,
  parameter logic [ROW_W-1:0] MR_OPER = '0
) (
  input  step_e            step,
  input  logic             fresh,
  input  logic             srt_fast,
  output logic             cke_n,
  output logic [3:0]       cmd_n,
  output logic [BA_W-1:0]  ba_n,
  output logic [ROW_W-1:0] addr_n,
  output logic             done_n
);

  always_comb begin
    cmd_n  = CMD_NOP;
    ba_n   = '0;
    addr_n = '0;
    cke_n  = !(step == ST_IDLE || step == ST_PWR);
    done_n = (step == ST_DONE);
    if (fresh) begin
      unique case (step)
        ST_PRE1, ST_PRE2: begin
          cmd_n      = CMD_PRE;
          addr_n[10] = 1'b1;
        end
        ST_EMR2: begin
          cmd_n     = CMD_MRS;
          ba_n      = BA_W'(2);
          addr_n[7] = srt_fast;
        end
        ST_EMR3: begin
          cmd_n = CMD_MRS;
          ba_n  = BA_W'(3);
        end
        ST_EMR1: begin
          cmd_n       = CMD_MRS;
          ba_n        = BA_W'(1);
          addr_n[9:7] = EMR1_HI;
        end
        ST_MRRST: begin
          cmd_n     = CMD_MRS;
          addr_n[8] = 1'b1;
        end
        ST_REF1, ST_REF2: cmd_n = CMD_REF;
        ST_MRFIN: begin
          cmd_n     = CMD_MRS;
          addr_n    = MR_OPER;
          addr_n[8] = 1'b0;
        end
        default: cmd_n = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int unsigned      CLK_MHZ      = 50,
  parameter int unsigned      PWR_WAIT_NS  = 200000,
  parameter int unsigned      CKE_WAIT_NS  = 400,
  parameter int unsigned      T_RP_NS      = 15,
  parameter int unsigned      T_RFC_NS     = 128,
  parameter int unsigned      T_MRD_CYC    = 2,
  parameter int unsigned      DLL_LOCK_CYC = 200,
  parameter int               ROW_W        = 14,
  parameter int               BA_W         = 3,
  parameter logic [2:0]       EMR1_HI      = 3'b000,
  parameter logic [ROW_W-1:0] MR_OPER      = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_stable,
  input  logic             srt_fast,
  output logic             cke,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [BA_W-1:0]  ba,
  output logic [ROW_W-1:0] addr,
  output logic             init_done
);

  localparam int unsigned PWR_C  = ns2cyc(PWR_WAIT_NS, CLK_MHZ);
  localparam int unsigned CKE_C  = ns2cyc(CKE_WAIT_NS, CLK_MHZ);
  localparam int unsigned RP_C   = ns2cyc(T_RP_NS, CLK_MHZ);
  localparam int unsigned RFC_C  = ns2cyc(T_RFC_NS, CLK_MHZ);
  localparam int unsigned MRD_C  = (T_MRD_CYC == 0) ? 1 : T_MRD_CYC;
  localparam int unsigned LOCK_C = (DLL_LOCK_CYC == 0) ? 1 : DLL_LOCK_CYC;
  localparam int unsigned MAX_C  = umax(umax(PWR_C, CKE_C), umax(umax(RP_C, RFC_C), MRD_C));
  localparam int          STEP_W = $clog2(MAX_C + 1);
  localparam int          LOCK_W = $clog2(LOCK_C + 1);

  // Cycles a step occupies, counting its command cycle.
  function automatic int unsigned step_dur(input step_e s);
    case (s)
      ST_PWR:                              return PWR_C;
      ST_CKEW:                             return CKE_C;
      ST_PRE1, ST_PRE2:                    return RP_C;
      ST_REF1, ST_REF2:                    return RFC_C;
      ST_EMR2, ST_EMR3, ST_EMR1, ST_MRRST,
      ST_MRFIN:                            return MRD_C;
      default:                             return 1;
    endcase
  endfunction

  step_e step_q, step_n;
  logic  fresh_q;
  logic  st_zero, lock_zero;
  logic  start, advance, move;

  assign start   = (step_q == ST_IDLE) && pwr_stable;
  assign advance = (step_q != ST_IDLE) && (step_q != ST_DONE) && st_zero &&
                   ((step_q != ST_MRFIN) || lock_zero);
  assign move    = start || advance;

  always_comb begin
    step_n = step_q;
    if (move) step_n = step_e'(step_q + 4'd1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q  <= ST_IDLE;
      fresh_q <= 1'b0;
    end else begin
      step_q  <= step_n;
      fresh_q <= move;
    end
  end

  init_dn_counter #(.W(STEP_W)) u_step_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (move),
    .load_val (STEP_W'(step_dur(step_n) - 1)),
    .zero     (st_zero)
  );

  init_dn_counter #(.W(LOCK_W)) u_lock_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (advance && (step_n == ST_MRRST)),
    .load_val (LOCK_W'(LOCK_C - 1)),
    .zero     (lock_zero)
  );

  logic             cke_d, done_d;
  logic [3:0]       cmd_d, cmd_q;
  logic [BA_W-1:0]  ba_d;
  logic [ROW_W-1:0] addr_d;

  init_cmd_decode #(
    .ROW_W   (ROW_W),
    .BA_W    (BA_W),
    .EMR1_HI (EMR1_HI),
    .MR_OPER (MR_OPER)
  ) u_decode (
    .step     (step_q),
    .fresh    (fresh_q),
    .srt_fast (srt_fast),
    .cke_n    (cke_d),
    .cmd_n    (cmd_d),
    .ba_n     (ba_d),
    .addr_n   (addr_d),
    .done_n   (done_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cke       <= 1'b0;
      cmd_q     <= CMD_NOP;
      ba        <= '0;
      addr      <= '0;
      init_done <= 1'b0;
    end else begin
      cke       <= cke_d;
      cmd_q     <= cmd_d;
      ba        <= ba_d;
      addr      <= addr_d;
      init_done <= done_d;
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;

  assert_nop_while_cke_low_R2: assert property (@(posedge clk) disable iff (rst)
    !cke |-> (cmd_q == CMD_NOP));

  assert_cke_never_falls_R3: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

  assert_precharge_all_banks_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_PRE) |-> (addr[10] && (ba == '0)));

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  assert_done_bus_parked_R10: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (cke && (cmd_q == CMD_NOP)));

  assert_done_after_lock_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> lock_zero);

  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> (!init_done && !cke));

endmodule

// File: tb/tb_ddr2_init_seq.sv
module tb_ddr2_init_seq;
  import ddr2_init_pkg::*;

  localparam int unsigned MHZ     = 50;
  localparam int unsigned PWR_C   = (200000 * MHZ + 999) / 1000;
  localparam int unsigned CKE_C   = (400 * MHZ + 999) / 1000;
  localparam int unsigned RP_C    = ((15 * MHZ + 999) / 1000 == 0) ? 1 : (15 * MHZ + 999) / 1000;
  localparam int unsigned RFC_C   = (128 * MHZ + 999) / 1000;
  localparam int unsigned MRD_C   = 2;
  localparam int unsigned LOCK_C  = 200;
  localparam logic [2:0]  E1HI    = 3'b101;
  localparam logic [13:0] MR_OP   = 14'h0163;
  localparam logic [13:0] MR_FIN  = MR_OP & ~14'h0100;

  // {cmd[3:0], ba[2:0], addr[13:0], gap[15:0]}
  localparam logic [36:0] VEC [9] = '{
    {4'b0010, 3'd0, 14'h0400, 16'(CKE_C)},
    {4'b0000, 3'd2, 14'h0000, 16'(RP_C)},
    {4'b0000, 3'd3, 14'h0000, 16'(MRD_C)},
    {4'b0000, 3'd1, {4'b0, E1HI, 7'b0}, 16'(MRD_C)},
    {4'b0000, 3'd0, 14'h0100, 16'(MRD_C)},
    {4'b0010, 3'd0, 14'h0400, 16'(MRD_C)},
    {4'b0001, 3'd0, 14'h0000, 16'(RP_C)},
    {4'b0001, 3'd0, 14'h0000, 16'(RFC_C)},
    {4'b0000, 3'd0, MR_FIN, 16'(RFC_C)}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, pwr_stable, srt_fast;
  logic        cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [2:0]  ba;
  logic [13:0] addr;

  ddr2_init_seq #(
    .CLK_MHZ (MHZ),
    .EMR1_HI (E1HI),
    .MR_OPER (MR_OP)
  ) dut (
    .clk        (clk),
    .rst        (rst),
    .pwr_stable (pwr_stable),
    .srt_fast   (srt_fast),
    .cke        (cke),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .ba         (ba),
    .addr       (addr),
    .init_done  (init_done)
  );

  wire [3:0] cmd = {cs_n, ras_n, cas_n, we_n};

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic string vec_tag(input int e);
    case (e)
      0: return "R4 R6 first precharge";
      1: return "R4 R7 ba2 load";
      2: return "R4 R8 ba3 load";
      3: return "R4 R8 ba1 load";
      4: return "R4 R9 dll reset load";
      5: return "R4 R6 second precharge";
      6: return "R4 R6 refresh one";
      7: return "R4 R6 refresh two";
      default: return "R4 R9 final load";
    endcase
  endfunction

  task automatic run_init(input logic srt);
    int low, gap, mr_cyc;
    logic nop_ok, cke_ok;
    logic [20:0] exp_w;
    srt_fast   = srt;
    pwr_stable = 1'b1;
    low = 0;
    nop_ok = 1'b1;
    forever begin
      @(negedge clk);
      if (cke) break;
      if (cmd != CMD_NOP) nop_ok = 1'b0;
      low++;
      if (low > int'(PWR_C) + 50) break;
    end
    chk("R2 cke low cycles", 64'(low), 64'(PWR_C + 1));
    chk("R2 only nop while cke low", 64'(nop_ok), 64'(1));
    cke_ok = 1'b1;
    mr_cyc = 0;
    for (int e = 0; e < 9; e++) begin
      gap = 0;
      do begin
        @(negedge clk);
        gap++;
        if (!cke) cke_ok = 1'b0;
      end while (cmd == CMD_NOP && gap < 2000);
      exp_w = VEC[e][36:16];
      if (e == 1) exp_w[7] = srt;
      chk(vec_tag(e), 64'({cmd, ba, addr}), 64'(exp_w));
      chk("R5 command spacing", 64'(gap), 64'(VEC[e][15:0]));
      if (e == 4) mr_cyc = cyc;
      if (e == 2) pwr_stable = 1'b0;
    end
    gap = 0;
    while (!init_done && gap < 2000) begin
      @(negedge clk);
      gap++;
      if (!cke) cke_ok = 1'b0;
    end
    chk("R10 done after dll lock", 64'(cyc - mr_cyc), 64'(LOCK_C));
    chk("R3 cke held with pwr_stable dropped", 64'(cke_ok), 64'(1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ok;
    rst = 1'b1; pwr_stable = 1'b0; srt_fast = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset cke", 64'(cke), 64'(0));
    chk("R1 reset outputs", 64'({cmd, ba, addr, init_done}), 64'({CMD_NOP, 3'd0, 14'd0, 1'b0}));
    rst = 1'b0;
    ok = 1'b1;
    repeat (40) begin
      @(negedge clk);
      if (cke || init_done || cmd != CMD_NOP || addr != 0 || ba != 0) ok = 1'b0;
    end
    chk("R1 idle without pwr_stable", 64'(ok), 64'(1));

    run_init(1'b1);

    ok = 1'b1;
    repeat (30) begin
      @(negedge clk);
      if (!init_done || !cke || cmd != CMD_NOP) ok = 1'b0;
    end
    chk("R10 done held with bus parked", 64'(ok), 64'(1));

    rst = 1'b1;
    @(negedge clk);
    chk("R11 reset from done", 64'({cke, init_done}), 64'(0));
    rst = 1'b0;
    pwr_stable = 1'b1;
    while (!cke) @(negedge clk);
    repeat (CKE_C + 6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R11 reset mid sequence", 64'({cke, init_done, cmd}), 64'({2'b00, CMD_NOP}));
    rst = 1'b0;
    pwr_stable = 1'b0;
    ok = 1'b1;
    repeat (25) begin
      @(negedge clk);
      if (cke || cmd != CMD_NOP) ok = 1'b0;
    end
    chk("R11 no restart without pwr_stable", 64'(ok), 64'(1));

    run_init(1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule